// File: doc/BRIEF.md
# Two-Source Strict-Priority Merge Arbiter

This block merges two producers onto a single registered output port. The first producer uses a valid/ready handshake. The second uses a valid signal with a wait back-pressure signal, and it groups its beats into packets with start and end markers. A three-state controller decides which producer is being serviced, and the first producer always wins when both are waiting at an arbitration point. The controller's state drives both back-pressure outputs directly.

Every accepted beat reaches the output one cycle after its handshake. It appears as a pulse on the output valid together with a flag that names its producer. A packet from the second producer is never interrupted. If the first producer raises a request in the middle of a packet, it waits until the packet's end beat has been taken.

Top module: `dual_src_prio_arb`

## Requirements
- R1: During and right after synchronous active-high reset, valid_out, sel_a and sel_b are 0, data_out is 0, ready_a is 0 and wait_b is 1.
- R2: In the idle state, a high valid_a moves the controller to servicing A on the next edge, where ready_a is 1 and wait_b is 1.
- R3: When valid_a is high and a valid_b beat with start_b is also pending in the idle state, A is serviced first and wait_b stays 1.
- R4: While servicing A, each cycle with valid_a and ready_a both high accepts data_a. The next cycle shows valid_out=1, sel_a=1, sel_b=0 and data_out equal to that data_a.
- R5: While servicing A, a cycle with valid_a low returns the controller to idle, so ready_a is 0 in the following cycle. ready_a is never 1 while wait_b is 0.
- R6: In the idle state with valid_a low, a valid_b beat with start_b high moves the controller to servicing B, where wait_b is 0 and ready_a is 0.
- R7: While servicing B, every cycle with valid_b high accepts data_b. The next cycle shows valid_out=1, sel_b=1, sel_a=0 and data_out equal to that data_b.
- R8: Once B service starts, ready_a stays 0 until the beat carrying end_b has been accepted, even if valid_a rises during the packet. After that beat the controller returns to idle.
- R9: In the idle state with valid_a low, a valid_b beat whose start_b is 0 does not start B service: wait_b stays 1 and no output beat is produced.
- R10: valid_out is high only in the cycle after an accepted beat, and then exactly one select flag is set. In cycles with no output beat both flags are 0 and data_out keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_a | input | 1 | Source A has a beat |
| data_a | input | DATA_W | Source A payload |
| ready_a | output | 1 | Source A beat is taken this cycle when valid_a is high |
| valid_b | input | 1 | Source B has a beat |
| data_b | input | DATA_W | Source B payload |
| start_b | input | 1 | First beat of a B packet |
| end_b | input | 1 | Last beat of a B packet |
| wait_b | output | 1 | Source B must hold its beat |
| valid_out | output | 1 | Output beat present |
| data_out | output | DATA_W | Output payload |
| sel_a | output | 1 | Output beat came from A |
| sel_b | output | 1 | Output beat came from B |

## Verification
The hardest case to reach is a request from A that arrives in the middle of a B packet. It needs B to win an idle cycle while A is quiet, and then A to rise before the end beat. The directed part of the bench builds exactly this sequence, with a packet of several beats and a bubble in it. A long protocol-respecting random phase adds further cases: A requests of varying length, packets of two to five beats, and stalled start beats. All of this is compared on every cycle against a behavioural model.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SVC_A = 2'd1,
    ST_SVC_B = 2'd2
  } arbState_t;

  typedef struct packed {
    logic takeA;
    logic takeB;
  } beatStrobe_t;
endpackage

// File: rtl/dsa_ctrl.sv
module dsa_ctrl
  import dsa_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validA,
  input  logic        validB,
  input  logic        startB,
  input  logic        endB,
  output logic        readyA,
  output logic        waitB,
  output beatStrobe_t strobe
);
  arbState_t curState, nxtState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_IDLE;
    else     curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_IDLE: begin
        if (validA)                nxtState = ST_SVC_A;
        else if (validB && startB) nxtState = ST_SVC_B;
      end
      ST_SVC_A: if (!validA)       nxtState = ST_IDLE;
      ST_SVC_B: if (validB && endB) nxtState = ST_IDLE;
      default:                      nxtState = ST_IDLE;
    endcase
  end

  always_comb begin
    readyA = (curState == ST_SVC_A);
    waitB  = (curState != ST_SVC_B);
    strobe.takeA = readyA && validA;
    strobe.takeB = !waitB && validB;
  end

  // R5: A is only served while B is stalled
  a_r5_ready_needs_wait: assert property (@(posedge clk) disable iff (rst)
    readyA |-> waitB);
  // R8: no A service inside an unfinished B packet
  a_r8_no_split: assert property (@(posedge clk) disable iff (rst)
    (!waitB && !(validB && endB)) |=> (!readyA && !waitB));
  // R9: a beat without start cannot open B service from idle
  a_r9_stray_beat: assert property (@(posedge clk) disable iff (rst)
    (waitB && !readyA && !validA && validB && !startB) |=> waitB);
  // R2: idle with an A request leads to A service
  a_r2_enter_a: assert property (@(posedge clk) disable iff (rst)
    (waitB && !readyA && validA) |=> readyA);
endmodule

// File: rtl/dsa_datapath.sv
module dsa_datapath
  import dsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  beatStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataA,
  input  logic [DATA_W-1:0] dataB,
  output logic              validOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              selA,
  output logic              selB
);
  logic              anyTake;
  logic [DATA_W-1:0] pickData;

  assign anyTake  = strobe.takeA | strobe.takeB;
  assign pickData = strobe.takeA ? dataA : dataB;

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      selA     <= 1'b0;
      selB     <= 1'b0;
      dataOut  <= '0;
    end else begin
      validOut <= anyTake;
      selA     <= strobe.takeA;
      selB     <= strobe.takeB;
      if (anyTake) dataOut <= pickData;
    end
  end

  // R4: an A handshake shows up one cycle later with its data
  a_r4_a_beat: assert property (@(posedge clk) disable iff (rst)
    strobe.takeA |=> (validOut && selA && !selB && dataOut == $past(dataA)));
  // R7: a B acceptance shows up one cycle later with its data
  a_r7_b_beat: assert property (@(posedge clk) disable iff (rst)
    strobe.takeB |=> (validOut && selB && !selA && dataOut == $past(dataB)));
  // R10: exactly one select flag per output beat
  a_r10_one_sel: assert property (@(posedge clk) disable iff (rst)
    validOut |-> ($countones({selA, selB}) == 1));
  // R10: idle cycles keep the payload and raise nothing
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !anyTake |=> (!validOut && !selA && !selB && $stable(dataOut)));
endmodule

// File: rtl/dual_src_prio_arb.sv
module dual_src_prio_arb
  import dsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_a,
  input  logic [DATA_W-1:0] data_a,
  output logic              ready_a,
  input  logic              valid_b,
  input  logic [DATA_W-1:0] data_b,
  input  logic              start_b,
  input  logic              end_b,
  output logic              wait_b,
  output logic              valid_out,
  output logic [DATA_W-1:0] data_out,
  output logic              sel_a,
  output logic              sel_b
);
  beatStrobe_t beatStrobe;

  dsa_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .validA (valid_a),
    .validB (valid_b),
    .startB (start_b),
    .endB   (end_b),
    .readyA (ready_a),
    .waitB  (wait_b),
    .strobe (beatStrobe)
  );

  dsa_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (beatStrobe),
    .dataA    (data_a),
    .dataB    (data_b),
    .validOut (valid_out),
    .dataOut  (data_out),
    .selA     (sel_a),
    .selB     (sel_b)
  );

  // R1: reset leaves no beat on the output
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!valid_out && !sel_a && !sel_b && !ready_a && wait_b));
endmodule

// File: tb/sim_dual_src_prio_arb.sv
module sim_dual_src_prio_arb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validA = 0, validB = 0, startB = 0, endB = 0;
  logic [W-1:0] dataA = '0, dataB = '0;
  logic readyA, waitB, validOut, selA, selB;
  logic [W-1:0] dataOut;

  always #5 clk = ~clk;

  dual_src_prio_arb #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst),
    .valid_a(validA), .data_a(dataA), .ready_a(readyA),
    .valid_b(validB), .data_b(dataB), .start_b(startB), .end_b(endB),
    .wait_b(waitB), .valid_out(validOut), .data_out(dataOut),
    .sel_a(selA), .sel_b(selB)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference: 0 idle, 1 serving A, 2 serving B
  int mState = 0;
  bit mValid = 0, mSelA = 0, mSelB = 0;
  logic [W-1:0] mData = '0;
  bit lastTakeA = 0, lastTakeB = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk(readyA === (mState == 1), "R5 ready_a", W'(readyA), W'(mState == 1));
    chk(waitB === (mState != 2), "R6 wait_b", W'(waitB), W'(mState != 2));
    chk(validOut === mValid, "R10 valid_out", W'(validOut), W'(mValid));
    chk(selA === mSelA, "R4 sel_a", W'(selA), W'(mSelA));
    chk(selB === mSelB, "R7 sel_b", W'(selB), W'(mSelB));
    chk(dataOut === mData, "R10 data_out", dataOut, mData);
  endtask

  // one cycle: compare, apply inputs, advance the model across the next edge
  task automatic step(input bit vA, input logic [W-1:0] dA, input bit vB,
                      input logic [W-1:0] dB, input bit sB, input bit eB);
    bit tA, tB;
    @(negedge clk);
    compareAll();
    validA = vA; dataA = dA; validB = vB; dataB = dB; startB = sB; endB = eB;
    tA = (mState == 1) && vA;
    tB = (mState == 2) && vB;
    mValid = tA || tB; mSelA = tA; mSelB = tB;
    if (tA) mData = dA; else if (tB) mData = dB;
    case (mState)
      0: if (vA) mState = 1; else if (vB && sB) mState = 2;
      1: if (!vA) mState = 0;
      2: if (vB && eB) mState = 0;
      default: mState = 0;
    endcase
    lastTakeA = tA; lastTakeB = tB;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; validA = 0; validB = 0; startB = 0; endB = 0; dataA = '0; dataB = '0;
    @(negedge clk);
    @(negedge clk);
    chk(!validOut && !selA && !selB && !readyA && waitB, "R1 in reset",
        W'({validOut, selA, selB, readyA, waitB}), W'(5'b00001));
    rst = 0;
    mState = 0; mValid = 0; mSelA = 0; mSelB = 0; mData = '0;
    lastTakeA = 0; lastTakeB = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    step(0, 0, 0, 0, 0, 0);
    chk(dataOut === '0 && !validOut && waitB, "R1 after reset", dataOut, '0);

    // R3: A and a B start beat both pending; A wins
    step(1, 32'hA1, 1, 32'hB1, 1, 0);
    step(1, 32'hA1, 1, 32'hB1, 1, 0);
    chk(readyA === 1'b1 && waitB === 1'b1, "R3 A first", W'({readyA, waitB}), W'(2'b11));
    step(1, 32'hA2, 1, 32'hB1, 1, 0);
    step(0, 0, 1, 32'hB1, 1, 0);
    step(0, 0, 1, 32'hB1, 1, 0);
    step(0, 0, 1, 32'hB2, 0, 0);
    // R8: A rises during the B packet and must wait
    step(1, 32'hA3, 0, 0, 0, 0);
    chk(readyA === 1'b0 && waitB === 1'b0, "R8 packet unbroken", W'({readyA, waitB}), W'(2'b00));
    step(1, 32'hA3, 1, 32'hB3, 0, 1);
    chk(readyA === 1'b0, "R8 before end taken", W'(readyA), 0);
    step(1, 32'hA3, 0, 0, 0, 0);
    step(1, 32'hA3, 0, 0, 0, 0);
    chk(readyA === 1'b1, "R8 A after packet", W'(readyA), 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // R9: a beat without start stays stalled in idle
    doReset();
    for (int i = 0; i < 4; i++) step(0, 0, 1, 32'h55, 0, 0);
    chk(waitB === 1'b1 && !validOut, "R9 stray beat", W'({waitB, validOut}), W'(2'b10));
    doReset();

    // random protocol-respecting traffic
    begin
      bit vA = 0, vB = 0, sB = 0, eB = 0, inPkt = 0;
      logic [W-1:0] dA = '0, dB = '0;
      int left = 0;
      for (int c = 0; c < 3000; c++) begin
        if (!(vA && !lastTakeA)) begin
          vA = ($urandom_range(0, 9) < 3);
          dA = $urandom;
        end
        if (!(vB && !lastTakeB)) begin
          vB = ($urandom_range(0, 9) < 6);
          if (vB) begin
            dB = $urandom;
            if (!inPkt) begin
              left = $urandom_range(1, 4);
              sB = 1; eB = 0; inPkt = 1;
            end else begin
              sB = 0; left--; eB = (left == 0);
              if (left == 0) inPkt = 0;
            end
          end else begin
            sB = 0; eB = 0;
          end
        end
        step(vA, dA, vB, dB, sB, eB);
      end
    end
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compareAll();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule